// File: doc/BRIEF.md
# Eight-Phase Receive Data Phase Selector

One serial receive lane delivers each bit period as a vector of eight samples. Sample k is taken k x 45 degrees after the bit clock edge, so there are eight evenly spaced sampling phases. The block counts where data transitions fall within the bit period over a fixed window of bits. It then moves its sampling point to the phase opposite the busiest transition position. This places sampling in the middle of the eye, where the receiver has the most skew margin. The block forwards one recovered bit for every valid sample vector.

Each lane uses its own instance, and each instance has its own bypass. A build-time parameter can force bypass permanently. At run time, dropping the enable input has the same effect. While bypassed, the lane samples at phase 0, which suits systems whose skew is known in advance and is corrected outside the block. A lock flag reports that the selected phase has settled.

Top module: `phs_sel_lane`

## Requirements
- R1: For every cycle with `smp_valid_i` high, `bit_valid_o` is high in the next cycle and `bit_o` equals bit `phase_o` of that cycle's `smp_i`. Bit k of `smp_i` is the sample at phase k. A cycle with `smp_valid_i` low gives `bit_valid_o` low in the next cycle.
- R2: The block defines eight transition positions. Position k, for k from 0 to 6, is a difference between `smp_i[k]` and `smp_i[k+1]`. Position 7 is a difference between `smp_i[0]` and bit 7 of the previous valid vector, which is 0 after reset.
- R3: While selection is active, every `WIN_BEATS` valid vectors close a window. After the closing vector, `phase_o` becomes (p + 4) mod 8, where p is the position with the highest transition count in that window. On a tie, the lowest such p is used.
- R4: A window with no transitions at any position leaves `phase_o` unchanged.
- R5: A new phase applies from the next valid vector onward. The bit recovered from the window-closing vector still uses the old phase.
- R6: `lock_o` rises at the close of a window whose choice equals the choice of the previous window since selection became active. It falls at the close of any window whose choice differs from the previous one. Between window closes it keeps its value.
- R7: With `sel_en_i` low, `phase_o` is 0 and `lock_o` is 0 in that same cycle, and bits come from sample 0. The window and its counts restart, so after re-enabling, the first window never sets `lock_o`.
- R8: With parameter `BYPASS` = 1, the lane behaves as in R7 whatever the value of `sel_en_i`.
- R9: After reset, `phase_o` is 0 and `lock_o`, `bit_valid_o` and `bit_o` are 0.
- R10: Vectors with `smp_valid_i` low add no transitions and do not advance the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample vector clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_i | input | 8 | Eight samples of one bit period, bit k at phase k x 45 degrees |
| smp_valid_i | input | 1 | `smp_i` holds a new bit period |
| sel_en_i | input | 1 | Run-time enable of phase selection; low bypasses |
| bit_o | output | 1 | Recovered bit |
| bit_valid_o | output | 1 | `bit_o` is new this cycle |
| phase_o | output | 3 | Selected sampling phase index |
| lock_o | output | 1 | Phase choice has settled |

## Verification
The bench builds two lanes that share the same inputs. The first uses `BYPASS` = 0 with `WIN_BEATS` = 16, so directed eyes, ties, empty windows and gaps in valid close several windows within a few hundred cycles. The second uses `BYPASS` = 1, so every vector also checks that the build-time bypass ignores the run-time enable and samples at phase 0. Random stretches vary the enable, the valid gaps and jittered transition positions around a drifting eye, and every cycle is compared with a reference model.

// File: rtl/phs_pkg.sv
package phs_pkg;
  localparam int unsigned NPH  = 8;
  localparam int unsigned PH_W = 3;

  typedef logic [PH_W-1:0] ph_t;

  // sampling phase half a bit away from a transition position
  function automatic ph_t ph_opposite(input ph_t pos);
    return ph_t'(pos + ph_t'(NPH / 2));
  endfunction
endpackage

// File: rtl/phs_edge_det.sv
module phs_edge_det
  import phs_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NPH-1:0] smp_i,
  input  logic           valid_i,
  output logic [NPH-1:0] edge_o
);
  logic last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      last_q <= 1'b0;
    else if (valid_i) last_q <= smp_i[NPH-1];
  end

  for (genvar k = 0; k < NPH - 1; k++) begin : g_in
    assign edge_o[k] = smp_i[k] ^ smp_i[k+1];
  end

  // boundary position spans previous vector's last sample
  assign edge_o[NPH-1] = last_q ^ smp_i[0];
endmodule

// File: rtl/phs_hist.sv
module phs_hist
  import phs_pkg::*;
#(
  parameter int unsigned WIN_BEATS = 64,
  localparam int unsigned CNT_W = $clog2(WIN_BEATS + 1),
  localparam int unsigned WIN_W = (WIN_BEATS > 1) ? $clog2(WIN_BEATS) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clr_i,
  input  logic                      inc_i,
  input  logic [NPH-1:0]            edge_i,
  output logic                      done_o,
  output logic [NPH-1:0][CNT_W-1:0] cnt_o
);
  logic [NPH-1:0][CNT_W-1:0] cnt_q;
  logic [WIN_W-1:0]          win_q;

  assign done_o = inc_i && (win_q == WIN_W'(WIN_BEATS - 1));

  // counts including the current vector, seen by the picker on close
  for (genvar k = 0; k < NPH; k++) begin : g_cnt
    assign cnt_o[k] = cnt_q[k] + CNT_W'(inc_i & edge_i[k]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      win_q <= '0;
    end else if (clr_i || done_o) begin
      cnt_q <= '0;
      win_q <= '0;
    end else if (inc_i) begin
      cnt_q <= cnt_o;
      win_q <= win_q + 1'b1;
    end
  end
endmodule

// File: rtl/phs_pick.sv
module phs_pick
  import phs_pkg::*;
#(
  parameter int unsigned CNT_W = 7
) (
  input  logic [NPH-1:0][CNT_W-1:0] cnt_i,
  input  ph_t                       cur_i,
  output ph_t                       cand_o
);
  logic [CNT_W-1:0] best;
  ph_t              pos;

  always_comb begin
    best = '0;
    pos  = '0;
    // strict compare keeps the lowest index on a tie
    for (int k = 0; k < NPH; k++) begin
      if (cnt_i[k] > best) begin
        best = cnt_i[k];
        pos  = ph_t'(k);
      end
    end
    cand_o = (best == '0) ? cur_i : ph_opposite(pos);
  end
endmodule

// File: rtl/phs_sel_lane.sv
module phs_sel_lane
  import phs_pkg::*;
#(
  parameter bit          BYPASS    = 1'b0,
  parameter int unsigned WIN_BEATS = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NPH-1:0]  smp_i,
  input  logic            smp_valid_i,
  input  logic            sel_en_i,
  output logic            bit_o,
  output logic            bit_valid_o,
  output logic [PH_W-1:0] phase_o,
  output logic            lock_o
);
  localparam int unsigned CNT_W = $clog2(WIN_BEATS + 1);
  localparam logic        BYP   = BYPASS;

  logic                      active;
  logic [NPH-1:0]            edges;
  logic                      win_done;
  logic [NPH-1:0][CNT_W-1:0] cnt_nxt;
  ph_t                       cand;
  ph_t                       phase_q, phase_eff;
  logic                      lock_q, have_q, bit_q, bvld_q;

  assign active    = sel_en_i & ~BYP;
  assign phase_eff = active ? phase_q : '0;

  phs_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .smp_i  (smp_i),
    .valid_i(smp_valid_i),
    .edge_o (edges)
  );

  phs_hist #(.WIN_BEATS(WIN_BEATS)) u_hist (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (~active),
    .inc_i (smp_valid_i & active),
    .edge_i(edges),
    .done_o(win_done),
    .cnt_o (cnt_nxt)
  );

  phs_pick #(.CNT_W(CNT_W)) u_pick (
    .cnt_i (cnt_nxt),
    .cur_i (phase_q),
    .cand_o(cand)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      lock_q  <= 1'b0;
      have_q  <= 1'b0;
    end else if (!active) begin
      phase_q <= '0;
      lock_q  <= 1'b0;
      have_q  <= 1'b0;
    end else if (win_done) begin
      phase_q <= cand;
      lock_q  <= have_q && (cand == phase_q);
      have_q  <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q  <= 1'b0;
      bvld_q <= 1'b0;
    end else begin
      bvld_q <= smp_valid_i;
      if (smp_valid_i) bit_q <= smp_i[phase_eff];
    end
  end

  assign bit_o       = bit_q;
  assign bit_valid_o = bvld_q;
  assign phase_o     = phase_eff;
  assign lock_o      = lock_q & active;
endmodule

// File: rtl/phs_sel_lane_chk.sv
module phs_sel_lane_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] smp_i,
  input logic       smp_valid_i,
  input logic       active,
  input logic [2:0] phase_q,
  input logic       lock_q,
  input logic       bit_o,
  input logic       bit_valid_o,
  input logic [2:0] phase_o,
  input logic       lock_o
);
  AST_VALID_ECHO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_i |=> bit_valid_o); // R1
  AST_NO_SPURIOUS_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> !bit_valid_o); // R1
  AST_BIT_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_i |=> (bit_o == $past(smp_i[phase_o]))); // R1
  AST_IDLE_PHASE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |-> (phase_o == 3'd0 && !lock_o)); // R7
  AST_PHASE_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(active) && phase_q != $past(phase_q)) |-> $past(smp_valid_i)); // R5
  AST_LOCK_RISE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_q) |-> (phase_q == $past(phase_q))); // R6
  AST_LOCK_DROP_ON_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(active) && phase_q != $past(phase_q)) |-> !lock_q); // R6
endmodule

bind phs_sel_lane phs_sel_lane_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .smp_i      (smp_i),
  .smp_valid_i(smp_valid_i),
  .active     (active),
  .phase_q    (phase_q),
  .lock_q     (lock_q),
  .bit_o      (bit_o),
  .bit_valid_o(bit_valid_o),
  .phase_o    (phase_o),
  .lock_o     (lock_o)
);

// File: tb/sim_phs_sel_lane.sv
module sim_phs_sel_lane;
  localparam int CLK_P = 10;
  localparam int WIN   = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] smp = '0;
  logic       vld = 1'b0;
  logic       sel_en = 1'b0;
  logic       b0, bv0, lk0, b1, bv1, lk1;
  logic [2:0] ph0, ph1;

  int  n_chk = 0;
  int  n_err = 0;
  bit  fin = 1'b0;

  // reference model state
  int   m_cnt[8];
  int   m_win, m_phase;
  bit   m_lock, m_have, m_bit, m_bvld, m_last;
  bit   dbit = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  phs_sel_lane #(.BYPASS(1'b0), .WIN_BEATS(WIN)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .smp_i(smp), .smp_valid_i(vld), .sel_en_i(sel_en),
    .bit_o(b0), .bit_valid_o(bv0), .phase_o(ph0), .lock_o(lk0));

  phs_sel_lane #(.BYPASS(1'b1), .WIN_BEATS(WIN)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .smp_i(smp), .smp_valid_i(vld), .sel_en_i(sel_en),
    .bit_o(b1), .bit_valid_o(bv1), .phase_o(ph1), .lock_o(lk1));

  task automatic chk_eq(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mk(input bit pb, input bit nb, input int e);
    logic [7:0] s;
    for (int k = 0; k < 8; k++) s[k] = (e != 7 && k <= e) ? pb : nb;
    return s;
  endfunction

  function automatic int pick(input int cur);
    int best = 0;
    int pos = 0;
    for (int k = 0; k < 8; k++) if (m_cnt[k] > best) begin best = m_cnt[k]; pos = k; end
    return (best == 0) ? cur : (pos + 4) % 8;
  endfunction

  task automatic mdl(input logic [7:0] s, input bit v, input bit en);
    int eff = en ? m_phase : 0;
    int c;
    m_bvld = v;
    if (v) m_bit = s[eff];
    if (!en) begin
      m_phase = 0; m_lock = 0; m_have = 0; m_win = 0;
      for (int k = 0; k < 8; k++) m_cnt[k] = 0;
    end else if (v) begin
      for (int k = 0; k < 7; k++) m_cnt[k] += int'(s[k] ^ s[k+1]);
      m_cnt[7] += int'(m_last ^ s[0]);
      m_win++;
      if (m_win == WIN) begin
        c = pick(m_phase);
        m_lock = m_have && (c == m_phase);
        m_have = 1;
        m_phase = c;
        m_win = 0;
        for (int k = 0; k < 8; k++) m_cnt[k] = 0;
      end
    end
    if (v) m_last = s[7];
  endtask

  task automatic beat(input logic [7:0] s, input bit v, input bit en);
    @(negedge clk);
    smp = s; vld = v; sel_en = en;
    mdl(s, v, en);
    @(posedge clk);
    #1;
    chk_eq("R1 bit_valid_o", int'(bv0), int'(m_bvld));
    if (m_bvld) chk_eq("R1 bit_o", int'(b0), int'(m_bit));
    chk_eq("R3 phase_o", int'(ph0), m_phase);
    chk_eq("R6 lock_o", int'(lk0), int'(m_lock));
    chk_eq("R8 bypass bit_valid_o", int'(bv1), int'(v));
    if (v) chk_eq("R8 bypass bit_o", int'(b1), int'(s[0]));
    chk_eq("R8 bypass phase_o", int'(ph1), 0);
    chk_eq("R8 bypass lock_o", int'(lk1), 0);
  endtask

  task automatic run(input int n, input int e, input bit tog, input bit en);
    bit nb;
    for (int i = 0; i < n; i++) begin
      nb = tog ? ~dbit : dbit;
      beat(mk(dbit, nb, e), 1'b1, en);
      dbit = nb;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!fin) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, s2;
    bit nb, v, en;
    int base, e;
    void'($urandom(32'h1bad5eed));
    m_win = 0; m_phase = 0; m_lock = 0; m_have = 0; m_bit = 0; m_bvld = 0; m_last = 0;
    for (int k = 0; k < 8; k++) m_cnt[k] = 0;

    repeat (3) @(posedge clk);
    #1;
    chk_eq("R9 reset phase_o", int'(ph0), 0);
    chk_eq("R9 reset lock_o", int'(lk0), 0);
    chk_eq("R9 reset bit_valid_o", int'(bv0), 0);
    chk_eq("R9 reset bit_o", int'(b0), 0);
    @(negedge clk); rst_n = 1'b1;

    // R7: run-time bypass samples phase 0
    run(4, 5, 1'b1, 1'b0);
    chk_eq("R7 disabled phase_o", int'(ph0), 0);

    // R3/R5/R6: eye edge at position 2 -> phase 6
    run(WIN - 1, 2, 1'b1, 1'b1);
    nb = ~dbit; s = mk(dbit, nb, 2); beat(s, 1'b1, 1'b1); dbit = nb;
    chk_eq("R5 closing bit uses old phase", int'(b0), int'(s[0]));
    chk_eq("R3 edge 2 gives phase 6", int'(ph0), 6);
    chk_eq("R6 first window no lock", int'(lk0), 0);
    nb = ~dbit; s2 = mk(dbit, nb, 2); beat(s2, 1'b1, 1'b1); dbit = nb;
    chk_eq("R5 next bit uses new phase", int'(b0), int'(s2[6]));
    run(WIN - 1, 2, 1'b1, 1'b1);
    chk_eq("R6 second equal window locks", int'(lk0), 1);

    // R2/R3: boundary position 7 -> phase 3, lock drops
    run(WIN, 7, 1'b1, 1'b1);
    chk_eq("R2 boundary edge gives phase 3", int'(ph0), 3);
    chk_eq("R6 lock falls on change", int'(lk0), 0);

    // R3 tie: positions 1 and 5 equal -> lowest (1) -> phase 5
    for (int i = 0; i < WIN / 2; i++) begin
      run(1, 1, 1'b1, 1'b1);
      run(1, 5, 1'b1, 1'b1);
    end
    chk_eq("R3 tie picks lowest position", int'(ph0), 5);

    // R4: no transitions keeps phase
    run(WIN, 0, 1'b0, 1'b1);
    chk_eq("R4 empty window keeps phase", int'(ph0), 5);
    chk_eq("R6 kept phase locks", int'(lk0), 1);

    // R10: invalid vectors with edges at 6 are ignored
    for (int i = 0; i < WIN; i++) begin
      run(1, 3, 1'b1, 1'b1);
      repeat (2) beat(mk(dbit, ~dbit, 6), 1'b0, 1'b1);
    end
    chk_eq("R10 invalid vectors ignored", int'(ph0), 7);

    // R7: disable then re-enable restarts lock qualification
    run(3, 2, 1'b1, 1'b0);
    chk_eq("R7 disabled phase_o", int'(ph0), 0);
    chk_eq("R7 disabled lock_o", int'(lk0), 0);
    run(WIN, 2, 1'b1, 1'b1);
    chk_eq("R7 re-enable phase", int'(ph0), 6);
    chk_eq("R7 re-enable first window no lock", int'(lk0), 0);
    run(WIN, 2, 1'b1, 1'b1);
    chk_eq("R7 re-enable second window locks", int'(lk0), 1);

    // random: drifting eye with jitter, gaps, occasional disable
    base = 3;
    for (int i = 0; i < 1200; i++) begin
      if (i % 150 == 149) base = (base + 1 + int'($urandom % 3)) % 8;
      en = ($urandom % 25) != 0;
      v  = ($urandom % 5) != 0;
      e  = (base + int'($urandom % 3) + 7) % 8;
      nb = ($urandom % 4) != 0 ? ~dbit : dbit;
      beat(mk(dbit, nb, e), v, en);
      if (v) dbit = nb;
    end

    fin = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule